// File: doc/BRIEF.md
# Dual-Clock Double-Rate Word-Pair FIFO

This block is a first-in first-out buffer between a write clock domain and a read clock domain that run independently. Storage is organised as word pairs. The internal path is twice the external word width, so one memory access moves two words. The external side is modelled as two lanes per clock: lane 0 carries the word that would travel on the rising edge, and lane 1 carries the word that would travel on the falling edge. No dual-edge I/O cells are needed.

Each port selects its own rate through a static mode pin. In double rate, one enable moves a full pair. In single rate, one enable moves one word on lane 0. The write side keeps a lone word until its partner arrives. The read side splits a fetched pair and hands out the lower word first. Any mix of rates is allowed. Pointers cross between the domains as Gray code through two-stage synchronisers. Each side shows full or empty and a threshold flag counted in words. Writes into a full FIFO and reads from an empty FIFO are dropped and set sticky error flags. The read side drives an echo strobe that pulses once for each delivery, a pair indicator, and an echo clock for the downstream receiver.

Top module: `ddr_fifo`

## Requirements
- R1: After reset the FIFO reports empty=1, almost-empty=1, full=0, almost-full=0, overflow=0, underflow=0 and echo strobe=0.
- R2: With write rate double (wr_ddr=1), one accepted enable stores two words: lane 0 is the earlier word and lane 1 the later one.
- R3: With read rate double (rd_ddr=1), one accepted enable delivers the next pair one read clock later: the earlier word on rd_lane0, the later word on rd_lane1, and rd_echo_pair=1.
- R4: With write rate single (wr_ddr=0), each accepted enable stores one word from lane 0. A lone odd word stays invisible to the read side, which keeps empty=1, until its partner is written.
- R5: With read rate single (rd_ddr=0), each accepted enable delivers one word on rd_lane0 in write order, lower word of a pair first, with rd_echo_pair=0.
- R6: The write rate and the read rate are chosen independently, and word order is preserved across mixed rates.
- R7: Full asserts on the write side once PAIRS pairs are stored. Empty asserts on the read side when no word is readable.
- R8: wr_almost_full=1 when the write-side level in words is at least AF_WORDS. rd_almost_empty=1 when the read-side level in words is at most AE_WORDS.
- R9: A write enable while full is ignored and sets wr_overflow, which stays set until reset.
- R10: A read enable while empty is ignored. It produces no echo strobe and sets rd_underflow, which stays set until reset.
- R11: rd_echo_en is high for exactly one read clock per accepted read, one cycle after the enable. The output lanes change only in those cycles.
- R12: rd_echo_clk follows rd_clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| wr_clk | input | 1 | Write clock |
| wr_ddr | input | 1 | Write rate: 1 double (pair per enable), 0 single |
| wr_en | input | 1 | Write enable |
| wr_lane0 | input | DATA_W | Earlier word, or the only word in single rate |
| wr_lane1 | input | DATA_W | Later word, used in double rate |
| wr_full | output | 1 | No write can be accepted |
| wr_almost_full | output | 1 | Write-side level in words at least AF_WORDS |
| wr_overflow | output | 1 | Sticky: a write was attempted while full |
| rd_clk | input | 1 | Read clock |
| rd_ddr | input | 1 | Read rate: 1 double, 0 single |
| rd_en | input | 1 | Read enable |
| rd_lane0 | output | DATA_W | Earlier (or only) delivered word |
| rd_lane1 | output | DATA_W | Later delivered word in double rate |
| rd_echo_en | output | 1 | One-cycle strobe marking new output data |
| rd_echo_pair | output | 1 | Both lanes carry new data |
| rd_echo_clk | output | 1 | Echo of the read clock |
| rd_empty | output | 1 | No word can be read |
| rd_almost_empty | output | 1 | Read-side level in words at most AE_WORDS |
| rd_underflow | output | 1 | Sticky: a read was attempted while empty |

## Verification
The properties assume that wr_ddr and rd_ddr change only while the FIFO is empty and both ports are idle, that AF_WORDS does not exceed twice PAIRS, and that enables and lane data are driven away from the clock edges. The bench changes modes only after a test has drained every word and waited for both synchronisers to settle. It drives all inputs on the falling edge of the clock that samples them and samples the flags only after enough cycles of both clocks for the pointer crossing to finish.

// File: rtl/ddrf_pkg.sv
package ddrf_pkg;
  typedef enum logic {
    RATE_SINGLE = 1'b0,
    RATE_DOUBLE = 1'b1
  } rate_e;
endpackage

// File: rtl/ddrf_rst_sync.sv
module ddrf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/ddrf_sync.sv
module ddrf_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/ddrf_mem.sv
module ddrf_mem #(
  parameter int PAIR_W = 32,
  parameter int PAIRS  = 8,
  localparam int AW    = $clog2(PAIRS)
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [PAIR_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [PAIR_W-1:0] rdata
);
  logic [PAIR_W-1:0] cell_q [PAIRS];

  always_ff @(posedge wclk) begin
    if (we) cell_q[waddr] <= wdata;
  end

  assign rdata = cell_q[raddr];
endmodule

// File: rtl/ddrf_wr_ctrl.sv
module ddrf_wr_ctrl
  import ddrf_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int PAIRS    = 8,
  parameter int AF_WORDS = 12,
  localparam int AW      = $clog2(PAIRS),
  localparam int PW      = AW + 1,
  localparam int LW      = PW + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode,
  input  logic                en,
  input  logic [DATA_W-1:0]   lane0,
  input  logic [DATA_W-1:0]   lane1,
  input  logic [PW-1:0]       rq_gray,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic [2*DATA_W-1:0] mem_data,
  output logic [PW-1:0]       wptr_gray,
  output logic                full,
  output logic                almost_full,
  output logic                overflow
);
  rate_e             rate;
  logic [PW-1:0]     wbin_q, wbin_d, wgray_q, wgray_d;
  logic [PW-1:0]     rq_bin, used;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              hold_vld_q, hold_vld_d;
  logic              ovf_q, ovf_d;
  logic              mem_full, full_int, push;
  logic [LW-1:0]     level;

  assign rate = rate_e'(mode);

  always_comb begin
    rq_bin[PW-1] = rq_gray[PW-1];
    for (int i = PW - 2; i >= 0; i--) rq_bin[i] = rq_bin[i+1] ^ rq_gray[i];
  end

  assign used     = wbin_q - rq_bin;
  assign mem_full = (used == PW'(PAIRS));
  assign full_int = mem_full && ((rate == RATE_DOUBLE) || hold_vld_q);
  assign level    = {used, 1'b0} + LW'(hold_vld_q);

  always_comb begin
    push       = 1'b0;
    mem_data   = '0;
    hold_d     = hold_q;
    hold_vld_d = hold_vld_q;
    if (en && !full_int) begin
      if (rate == RATE_DOUBLE) begin
        push     = 1'b1;
        mem_data = {lane1, lane0};
      end else if (hold_vld_q) begin
        push       = 1'b1;
        mem_data   = {lane0, hold_q};
        hold_vld_d = 1'b0;
      end else begin
        hold_d     = lane0;
        hold_vld_d = 1'b1;
      end
    end
    wbin_d  = wbin_q + PW'(push);
    wgray_d = wbin_d ^ (wbin_d >> 1);
    ovf_d   = ovf_q | (en & full_int);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q     <= '0;
      wgray_q    <= '0;
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
      ovf_q      <= 1'b0;
    end else begin
      wbin_q     <= wbin_d;
      wgray_q    <= wgray_d;
      hold_q     <= hold_d;
      hold_vld_q <= hold_vld_d;
      ovf_q      <= ovf_d;
    end
  end

  assign mem_we      = push;
  assign mem_addr    = wbin_q[AW-1:0];
  assign wptr_gray   = wgray_q;
  assign full        = full_int;
  assign almost_full = (level >= LW'(AF_WORDS));
  assign overflow    = ovf_q;
endmodule

// File: rtl/ddrf_rd_ctrl.sv
module ddrf_rd_ctrl
  import ddrf_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int PAIRS    = 8,
  parameter int AE_WORDS = 2,
  localparam int AW      = $clog2(PAIRS),
  localparam int PW      = AW + 1,
  localparam int LW      = PW + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode,
  input  logic                en,
  input  logic [PW-1:0]       wq_gray,
  input  logic [2*DATA_W-1:0] mem_rdata,
  output logic [AW-1:0]       mem_addr,
  output logic [PW-1:0]       rptr_gray,
  output logic [DATA_W-1:0]   lane0,
  output logic [DATA_W-1:0]   lane1,
  output logic                echo_en,
  output logic                echo_pair,
  output logic                empty,
  output logic                almost_empty,
  output logic                underflow
);
  rate_e             rate;
  logic [PW-1:0]     rbin_q, rbin_d, rgray_q, rgray_d;
  logic [PW-1:0]     wq_bin, avail;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              hold_vld_q, hold_vld_d;
  logic [DATA_W-1:0] lane0_q, lane0_d, lane1_q, lane1_d;
  logic              echo_q, echo_d, pair_q, pair_d;
  logic              unf_q, unf_d;
  logic              mem_empty, empty_int, pop, accept;
  logic [LW-1:0]     level;

  assign rate = rate_e'(mode);

  always_comb begin
    wq_bin[PW-1] = wq_gray[PW-1];
    for (int i = PW - 2; i >= 0; i--) wq_bin[i] = wq_bin[i+1] ^ wq_gray[i];
  end

  assign avail     = wq_bin - rbin_q;
  assign mem_empty = (avail == '0);
  assign empty_int = (rate == RATE_DOUBLE) ? mem_empty : (mem_empty && !hold_vld_q);
  assign level     = {avail, 1'b0} + LW'(hold_vld_q);
  assign accept    = en && !empty_int;

  always_comb begin
    pop        = 1'b0;
    hold_d     = hold_q;
    hold_vld_d = hold_vld_q;
    lane0_d    = lane0_q;
    lane1_d    = lane1_q;
    echo_d     = accept;
    pair_d     = accept && (rate == RATE_DOUBLE);
    if (accept) begin
      if (rate == RATE_DOUBLE) begin
        pop     = 1'b1;
        lane0_d = mem_rdata[DATA_W-1:0];
        lane1_d = mem_rdata[2*DATA_W-1:DATA_W];
      end else if (hold_vld_q) begin
        lane0_d    = hold_q;
        hold_vld_d = 1'b0;
      end else begin
        pop        = 1'b1;
        lane0_d    = mem_rdata[DATA_W-1:0];
        hold_d     = mem_rdata[2*DATA_W-1:DATA_W];
        hold_vld_d = 1'b1;
      end
    end
    rbin_d  = rbin_q + PW'(pop);
    rgray_d = rbin_d ^ (rbin_d >> 1);
    unf_d   = unf_q | (en & empty_int);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q     <= '0;
      rgray_q    <= '0;
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
      lane0_q    <= '0;
      lane1_q    <= '0;
      echo_q     <= 1'b0;
      pair_q     <= 1'b0;
      unf_q      <= 1'b0;
    end else begin
      rbin_q     <= rbin_d;
      rgray_q    <= rgray_d;
      hold_q     <= hold_d;
      hold_vld_q <= hold_vld_d;
      lane0_q    <= lane0_d;
      lane1_q    <= lane1_d;
      echo_q     <= echo_d;
      pair_q     <= pair_d;
      unf_q      <= unf_d;
    end
  end

  assign mem_addr     = rbin_q[AW-1:0];
  assign rptr_gray    = rgray_q;
  assign lane0        = lane0_q;
  assign lane1        = lane1_q;
  assign echo_en      = echo_q;
  assign echo_pair    = pair_q;
  assign empty        = empty_int;
  assign almost_empty = (level <= LW'(AE_WORDS));
  assign underflow    = unf_q;
endmodule

// File: rtl/ddr_fifo.sv
module ddr_fifo #(
  parameter int DATA_W   = 16,
  parameter int PAIRS    = 8,
  parameter int AF_WORDS = 12,
  parameter int AE_WORDS = 2
) (
  input  logic              rst_n,
  input  logic              wr_clk,
  input  logic              wr_ddr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_lane0,
  input  logic [DATA_W-1:0] wr_lane1,
  output logic              wr_full,
  output logic              wr_almost_full,
  output logic              wr_overflow,
  input  logic              rd_clk,
  input  logic              rd_ddr,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_lane0,
  output logic [DATA_W-1:0] rd_lane1,
  output logic              rd_echo_en,
  output logic              rd_echo_pair,
  output logic              rd_echo_clk,
  output logic              rd_empty,
  output logic              rd_almost_empty,
  output logic              rd_underflow
);
  localparam int AW     = $clog2(PAIRS);
  localparam int PW     = AW + 1;
  localparam int PAIR_W = 2 * DATA_W;

  logic              wr_srst_n, rd_srst_n;
  logic [PW-1:0]     wptr_gray, rptr_gray, wq_gray, rq_gray;
  logic              mem_we;
  logic [AW-1:0]     mem_waddr, mem_raddr;
  logic [PAIR_W-1:0] mem_wdata, mem_rdata;

  ddrf_rst_sync i_wr_rst (.clk(wr_clk), .arst_n(rst_n), .srst_n(wr_srst_n));
  ddrf_rst_sync i_rd_rst (.clk(rd_clk), .arst_n(rst_n), .srst_n(rd_srst_n));

  ddrf_sync #(.W(PW)) i_rptr_to_wr (
    .clk(wr_clk), .rst_n(wr_srst_n), .d(rptr_gray), .q(rq_gray)
  );
  ddrf_sync #(.W(PW)) i_wptr_to_rd (
    .clk(rd_clk), .rst_n(rd_srst_n), .d(wptr_gray), .q(wq_gray)
  );

  ddrf_mem #(.PAIR_W(PAIR_W), .PAIRS(PAIRS)) i_mem (
    .wclk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  ddrf_wr_ctrl #(.DATA_W(DATA_W), .PAIRS(PAIRS), .AF_WORDS(AF_WORDS)) i_wr (
    .clk(wr_clk), .rst_n(wr_srst_n), .mode(wr_ddr), .en(wr_en),
    .lane0(wr_lane0), .lane1(wr_lane1), .rq_gray(rq_gray),
    .mem_we(mem_we), .mem_addr(mem_waddr), .mem_data(mem_wdata),
    .wptr_gray(wptr_gray), .full(wr_full), .almost_full(wr_almost_full),
    .overflow(wr_overflow)
  );

  ddrf_rd_ctrl #(.DATA_W(DATA_W), .PAIRS(PAIRS), .AE_WORDS(AE_WORDS)) i_rd (
    .clk(rd_clk), .rst_n(rd_srst_n), .mode(rd_ddr), .en(rd_en),
    .wq_gray(wq_gray), .mem_rdata(mem_rdata), .mem_addr(mem_raddr),
    .rptr_gray(rptr_gray), .lane0(rd_lane0), .lane1(rd_lane1),
    .echo_en(rd_echo_en), .echo_pair(rd_echo_pair), .empty(rd_empty),
    .almost_empty(rd_almost_empty), .underflow(rd_underflow)
  );

  assign rd_echo_clk = rd_clk;
endmodule

// File: rtl/ddr_fifo_chk.sv
module ddr_fifo_chk #(
  parameter int DATA_W = 16,
  parameter int PW     = 4
) (
  input logic              rst_n,
  input logic              wr_clk,
  input logic              wr_en,
  input logic              wr_full,
  input logic              wr_almost_full,
  input logic              wr_overflow,
  input logic              rd_clk,
  input logic              rd_en,
  input logic              rd_empty,
  input logic              rd_echo_en,
  input logic [DATA_W-1:0] rd_lane0,
  input logic [DATA_W-1:0] rd_lane1,
  input logic              rd_underflow,
  input logic [PW-1:0]     wptr_gray
);
  // R9: a write attempt while full raises the overflow flag
  a_r9_overflow_on_full: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_en && wr_full) |=> wr_overflow);

  // R9: overflow flag is sticky
  a_r9_overflow_sticky: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_overflow |=> wr_overflow);

  // R8: full always implies the almost-full threshold is reached
  a_r8_full_implies_almost: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_full |-> wr_almost_full);

  // R10: underflow flag is sticky
  a_r10_underflow_sticky: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_underflow |=> rd_underflow);

  // R11: an echo strobe is always caused by an accepted read one cycle earlier
  a_r11_echo_from_read: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_echo_en |-> ($past(rd_en) && !$past(rd_empty)));

  // R11: output lanes do not move without an echo strobe
  a_r11_lanes_hold: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !rd_echo_en |-> ($stable(rd_lane0) && $stable(rd_lane1)));

  // R7: the write pointer moves by a single Gray step per cycle
  a_r7_gray_single_step: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $countones(wptr_gray ^ $past(wptr_gray)) <= 1);
endmodule

bind ddr_fifo ddr_fifo_chk #(.DATA_W(DATA_W), .PW(PW)) i_chk (
  .rst_n(rst_n), .wr_clk(wr_clk), .wr_en(wr_en), .wr_full(wr_full),
  .wr_almost_full(wr_almost_full), .wr_overflow(wr_overflow),
  .rd_clk(rd_clk), .rd_en(rd_en), .rd_empty(rd_empty),
  .rd_echo_en(rd_echo_en), .rd_lane0(rd_lane0), .rd_lane1(rd_lane1),
  .rd_underflow(rd_underflow), .wptr_gray(wptr_gray)
);

// File: tb/test_ddr_fifo.sv
`timescale 1ns/1ps
module test_ddr_fifo;
  localparam int DW    = 16;
  localparam int PAIRS = 8;

  logic rst_n, wr_clk, rd_clk;
  logic wr_ddr, wr_en, rd_ddr, rd_en;
  logic [DW-1:0] wr_lane0, wr_lane1, rd_lane0, rd_lane1;
  logic wr_full, wr_almost_full, wr_overflow;
  logic rd_echo_en, rd_echo_pair, rd_echo_clk, rd_empty, rd_almost_empty, rd_underflow;

  int total = 0;
  int fails = 0;

  ddr_fifo #(.DATA_W(DW), .PAIRS(PAIRS), .AF_WORDS(12), .AE_WORDS(2)) i_ddr_fifo (
    .rst_n(rst_n), .wr_clk(wr_clk), .wr_ddr(wr_ddr), .wr_en(wr_en),
    .wr_lane0(wr_lane0), .wr_lane1(wr_lane1), .wr_full(wr_full),
    .wr_almost_full(wr_almost_full), .wr_overflow(wr_overflow),
    .rd_clk(rd_clk), .rd_ddr(rd_ddr), .rd_en(rd_en), .rd_lane0(rd_lane0),
    .rd_lane1(rd_lane1), .rd_echo_en(rd_echo_en), .rd_echo_pair(rd_echo_pair),
    .rd_echo_clk(rd_echo_clk), .rd_empty(rd_empty),
    .rd_almost_empty(rd_almost_empty), .rd_underflow(rd_underflow)
  );

  initial wr_clk = 1'b0;
  always #4 wr_clk = ~wr_clk;
  initial rd_clk = 1'b0;
  always #5.5 rd_clk = ~rd_clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_beat(input logic [DW-1:0] a, input logic [DW-1:0] b);
    @(negedge wr_clk);
    wr_en = 1'b1; wr_lane0 = a; wr_lane1 = b;
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_beat(output logic [DW-1:0] a, output logic [DW-1:0] b,
                         output logic e, output logic p);
    @(negedge rd_clk);
    rd_en = 1'b1;
    @(negedge rd_clk);
    rd_en = 1'b0;
    a = rd_lane0; b = rd_lane1; e = rd_echo_en; p = rd_echo_pair;
  endtask

  task automatic settle();
    repeat (5) @(negedge wr_clk);
    repeat (5) @(negedge rd_clk);
  endtask

  task automatic t_reset();
    chk("R1 empty", rd_empty, 1);
    chk("R1 almost_empty", rd_almost_empty, 1);
    chk("R1 full", wr_full, 0);
    chk("R1 almost_full", wr_almost_full, 0);
    chk("R1 overflow", wr_overflow, 0);
    chk("R1 underflow", rd_underflow, 0);
    chk("R1 echo", rd_echo_en, 0);
  endtask

  task automatic t_echo_clk();
    @(posedge rd_clk); #1;
    chk("R12 echo clk high", rd_echo_clk, 1);
    @(negedge rd_clk); #1;
    chk("R12 echo clk low", rd_echo_clk, 0);
  endtask

  task automatic t_ddr_ddr();
    logic [DW-1:0] a, b; logic e, p;
    wr_ddr = 1'b1; rd_ddr = 1'b1;
    for (int i = 0; i < 3; i++) wr_beat(DW'(16'h1000 + 2*i), DW'(16'h1001 + 2*i));
    settle();
    for (int i = 0; i < 3; i++) begin
      rd_beat(a, b, e, p);
      chk("R2 R3 lane0", a, 16'h1000 + 2*i);
      chk("R2 R3 lane1", b, 16'h1001 + 2*i);
      chk("R11 echo on read", e, 1);
      chk("R3 pair flag", p, 1);
    end
    @(negedge rd_clk);
    chk("R11 echo one cycle", rd_echo_en, 0);
    chk("R11 lane0 held", rd_lane0, 16'h1004);
    chk("R7 empty after drain", rd_empty, 1);
  endtask

  task automatic t_sdr_in();
    logic [DW-1:0] a, b; logic e, p;
    wr_ddr = 1'b0; rd_ddr = 1'b1;
    wr_beat(16'h2000, 16'hDEAD);
    settle();
    chk("R4 lone word held", rd_empty, 1);
    wr_beat(16'h2001, 16'hDEAD);
    settle();
    chk("R4 pair visible", rd_empty, 0);
    wr_beat(16'h2002, 16'hDEAD);
    wr_beat(16'h2003, 16'hDEAD);
    settle();
    for (int i = 0; i < 2; i++) begin
      rd_beat(a, b, e, p);
      chk("R6 sdr-in lane0", a, 16'h2000 + 2*i);
      chk("R6 sdr-in lane1", b, 16'h2001 + 2*i);
    end
    settle();
    chk("R7 empty sdr-in", rd_empty, 1);
  endtask

  task automatic t_sdr_out();
    logic [DW-1:0] a, b; logic e, p;
    wr_ddr = 1'b1; rd_ddr = 1'b0;
    wr_beat(16'h3000, 16'h3001);
    wr_beat(16'h3002, 16'h3003);
    settle();
    for (int i = 0; i < 4; i++) begin
      rd_beat(a, b, e, p);
      chk("R5 sdr-out word", a, 16'h3000 + i);
      chk("R5 pair flag low", p, 0);
      chk("R11 echo per word", e, 1);
    end
    settle();
    chk("R5 empty after words", rd_empty, 1);
  endtask

  task automatic t_almost();
    logic [DW-1:0] a, b; logic e, p;
    wr_ddr = 1'b1; rd_ddr = 1'b1;
    wr_beat(16'h4000, 16'h4001);
    settle();
    chk("R8 almost_empty at 2 words", rd_almost_empty, 1);
    wr_beat(16'h4002, 16'h4003);
    settle();
    chk("R8 almost_empty at 4 words", rd_almost_empty, 0);
    for (int i = 2; i < 5; i++) wr_beat(DW'(16'h4000 + 2*i), DW'(16'h4001 + 2*i));
    chk("R8 almost_full at 10 words", wr_almost_full, 0);
    wr_beat(16'h400A, 16'h400B);
    chk("R8 almost_full at 12 words", wr_almost_full, 1);
    chk("R7 not full at 6 pairs", wr_full, 0);
    settle();
    for (int i = 0; i < 6; i++) begin
      rd_beat(a, b, e, p);
      chk("R8 drain lane0", a, 16'h4000 + 2*i);
      chk("R8 drain lane1", b, 16'h4001 + 2*i);
    end
    settle();
    chk("R8 almost_full cleared", wr_almost_full, 0);
  endtask

  task automatic t_underflow();
    logic [DW-1:0] a, b; logic e, p;
    chk("R10 underflow clear before", rd_underflow, 0);
    rd_beat(a, b, e, p);
    chk("R10 no echo on empty", e, 0);
    chk("R10 underflow set", rd_underflow, 1);
    chk("R10 still empty", rd_empty, 1);
    chk("R10 lane0 untouched", a, 16'h400A);
    repeat (3) @(negedge rd_clk);
    chk("R10 underflow sticky", rd_underflow, 1);
  endtask

  task automatic t_overflow();
    logic [DW-1:0] a, b; logic e, p;
    wr_ddr = 1'b1; rd_ddr = 1'b1;
    for (int i = 0; i < PAIRS; i++) wr_beat(DW'(16'h5000 + 2*i), DW'(16'h5001 + 2*i));
    chk("R7 full at PAIRS", wr_full, 1);
    chk("R9 no overflow yet", wr_overflow, 0);
    wr_beat(16'h9999, 16'h9999);
    chk("R9 overflow set", wr_overflow, 1);
    settle();
    for (int i = 0; i < PAIRS; i++) begin
      rd_beat(a, b, e, p);
      chk("R9 stored lane0", a, 16'h5000 + 2*i);
      chk("R9 stored lane1", b, 16'h5001 + 2*i);
    end
    settle();
    chk("R9 dropped pair absent", rd_empty, 1);
    chk("R7 full cleared", wr_full, 0);
    chk("R9 overflow sticky", wr_overflow, 1);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    wr_ddr = 1'b1; rd_ddr = 1'b1; wr_lane0 = '0; wr_lane1 = '0;
    repeat (5) @(negedge wr_clk);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_echo_clk();
    t_ddr_ddr();
    t_sdr_in();
    t_sdr_out();
    t_almost();
    t_underflow();
    t_overflow();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge wr_clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule